// File: doc/BRIEF.md
# Strided Load and Halving-Fold Integer Sum Engine

This block adds up the signed 32-bit integers in one slice of a vector held in an external memory. A dispatch is split into a number of virtual groups, and the engine computes the total for one chosen group per run. Its `LANES` parallel lanes each own one scratch slot. In the load phase, every lane reads two elements that are `LANES` apart in each cycle. It adds both into its slot. The read window then advances by a grid-wide stride of `2*LANES*groups`, until the window start reaches the element count.

In the fold phase, the slots are combined pairwise. The stride starts at `LANES/2` and halves every cycle. Only lanes below the stride add in their partner slot at `lane + stride`. After the last fold step, slot 0 holds the group total. The engine raises `done_o` for one cycle with the total on `sum_o`.

A caller sets the element count, the group count and the group index, then pulses `start_i`. Running the engine once per group gives one partial sum per group. A later run over those partial sums can combine them.

Top module: `tree_sum_engine`

## Requirements
- R1: After reset, `done_o` is 0 and `sum_o` is 0.
- R2: The result is the wrapping 32-bit sum of every element `k < n` whose block number `k / (2*LANES)`, taken modulo the group count, equals the group index. A group count of 0 is treated as 1.
- R3: The read bus carries `2*LANES` addresses of `IW` bits each. Entry `j` sits at bits `[j*IW +: IW]` and equals `base + j`. `base` starts at `group_index*2*LANES` in the first load cycle and grows by `2*LANES*groups` each load cycle.
- R4: An element read at an index at or beyond `n` adds nothing to the sum.
- R5: The load phase always runs at least one cycle. It ends after the cycle in which `base + stride` reaches or passes `n`.
- R6: The fold phase takes exactly `log2(LANES)` cycles. `done_o` rises the cycle after the last fold step, so the start-to-done latency is `loads + log2(LANES)` clock edges after the edge that accepts `start_i`.
- R7: `done_o` is high for exactly one cycle, and `sum_o` holds the result during that cycle.
- R8: While a run is in progress, `start_i` and changes to the count and group inputs have no effect on the run.
- R9: Accumulation is 32-bit two's complement and wraps on overflow.
- R10: Every scratch slot is cleared when a run is accepted, so no run depends on an earlier one.
- R11: The sixteen values 10, 1, 8, -1, 0, -2, 3, 5, -2, -3, 2, 7, 0, 11, 0, 2 sum to 41.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a run; accepted only when idle |
| elem_count_i | input | IW+1 | Number of valid elements n |
| grp_count_i | input | GW | Number of virtual groups (0 treated as 1) |
| grp_idx_i | input | GW | Group whose sum is computed |
| rd_addr_o | output | 2*LANES*IW | Element addresses, entry j = base + j |
| rd_data_i | input | 2*LANES*DW | Element data, same entry order, same cycle |
| done_o | output | 1 | One-cycle result strobe |
| sum_o | output | DW | Group total, valid with done_o |

## Verification
The assertions assume that the memory answers in the same cycle as the address. They also assume that the count and group inputs are sampled only on the accepting edge. The first-address property reads the group index one edge back, and the bench drives start and those inputs together at a falling edge.

The stride-step property assumes that one run's addresses do not wrap beyond `IW` bits in a way that matters. The bench keeps `n` at most 1023, so the memory model is always indexed inside its array.

In one run, the bench changes the count and group inputs in mid-run to test that they are ignored. In the other runs, it holds them steady through the run, so the hold properties match what a real caller would do.

// File: rtl/tree_sum_pkg.sv
package tree_sum_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_LOAD,
      ST_FOLD,
      ST_DONE
   } sum_state_e;

   function automatic bit is_pow2(int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/tree_sum_ctrl.sv
module tree_sum_ctrl
   import tree_sum_pkg::*;
#(
   parameter int LANES = 8,
   parameter int IW    = 10,
   parameter int GW    = 4,
   parameter int BW    = 20,
   parameter int SW    = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [IW:0]   elem_count_i,
   input  logic [GW-1:0] grp_count_i,
   input  logic [GW-1:0] grp_idx_i,
   output logic          clr_o,
   output logic          ld_o,
   output logic          fold_o,
   output logic          busy_o,
   output logic          done_o,
   output logic [SW-1:0] step_o,
   output logic [BW-1:0] base_o,
   output logic [BW-1:0] stride_o,
   output logic [IW:0]   count_o
);
   localparam int LOG2B = $clog2(LANES);
   localparam int SHIFT = LOG2B + 1;

   sum_state_e    state_q;
   logic [BW-1:0] base_q, stride_q, base_nxt;
   logic [IW:0]   count_q;
   logic [SW-1:0] step_q;
   logic [GW-1:0] grp_eff;

   assign grp_eff  = (grp_count_i == '0) ? GW'(1) : grp_count_i;
   assign base_nxt = base_q + stride_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         base_q   <= '0;
         stride_q <= '0;
         count_q  <= '0;
         step_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (start_i) begin
               state_q  <= ST_LOAD;
               count_q  <= elem_count_i;
               base_q   <= BW'(grp_idx_i) << SHIFT;
               stride_q <= BW'(grp_eff) << SHIFT;
            end
            ST_LOAD: begin
               base_q <= base_nxt;
               if (base_nxt >= BW'(count_q)) begin
                  state_q <= ST_FOLD;
                  step_q  <= '0;
               end
            end
            ST_FOLD: begin
               if (step_q == SW'(LOG2B - 1)) state_q <= ST_DONE;
               else                          step_q  <= step_q + 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign clr_o    = start_i && (state_q == ST_IDLE);
   assign ld_o     = (state_q == ST_LOAD);
   assign fold_o   = (state_q == ST_FOLD);
   assign done_o   = (state_q == ST_DONE);
   assign busy_o   = (state_q != ST_IDLE);
   assign step_o   = step_q;
   assign base_o   = base_q;
   assign stride_o = stride_q;
   assign count_o  = count_q;
endmodule

// File: rtl/tree_sum_scratch.sv
module tree_sum_scratch #(
   parameter int LANES = 8,
   parameter int DW    = 32,
   parameter int IW    = 10,
   parameter int BW    = 20,
   parameter int SW    = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr_i,
   input  logic                  ld_i,
   input  logic                  fold_i,
   input  logic [SW-1:0]         step_i,
   input  logic [BW-1:0]         base_i,
   input  logic [IW:0]           count_i,
   input  logic [2*LANES*DW-1:0] rd_data_i,
   output logic [DW-1:0]         sum_o
);
   localparam int LOG2B = $clog2(LANES);

   logic [DW-1:0] acc_w [LANES];

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [DW-1:0] acc_q, lo_val, hi_val, partner;
      logic          lo_ok, hi_ok;
      logic [DW-1:0] part_k [LOG2B];

      // element at base+l and its twin LANES further on; masked past n
      assign lo_ok  = (base_i + BW'(l)) < BW'(count_i);
      assign hi_ok  = (base_i + BW'(LANES + l)) < BW'(count_i);
      assign lo_val = lo_ok ? rd_data_i[l*DW +: DW] : '0;
      assign hi_val = hi_ok ? rd_data_i[(LANES + l)*DW +: DW] : '0;

      // partner slot for each fold step, stride LANES>>(k+1)
      for (genvar k = 0; k < LOG2B; k++) begin : g_step
         localparam int S = LANES >> (k + 1);
         if (l < S) begin : g_act
            assign part_k[k] = acc_w[l + S];
         end else begin : g_idle
            assign part_k[k] = '0;
         end
      end

      always_comb begin
         partner = '0;
         for (int kk = 0; kk < LOG2B; kk++)
            if (step_i == SW'(kk)) partner = part_k[kk];
      end

      always_ff @(posedge clk) begin
         if (!rst_n)      acc_q <= '0;
         else if (clr_i)  acc_q <= '0;
         else if (ld_i)   acc_q <= acc_q + lo_val + hi_val;
         else if (fold_i) acc_q <= acc_q + partner;
      end

      assign acc_w[l] = acc_q;
   end

   assign sum_o = acc_w[0];
endmodule

// File: rtl/tree_sum_engine.sv
module tree_sum_engine
   import tree_sum_pkg::*;
#(
   parameter int LANES = 8,
   parameter int DW    = 32,
   parameter int IW    = 10,
   parameter int GW    = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic [IW:0]           elem_count_i,
   input  logic [GW-1:0]         grp_count_i,
   input  logic [GW-1:0]         grp_idx_i,
   output logic [2*LANES*IW-1:0] rd_addr_o,
   input  logic [2*LANES*DW-1:0] rd_data_i,
   output logic                  done_o,
   output logic [DW-1:0]         sum_o
);
   localparam int LOG2B = $clog2(LANES);
   localparam int BW    = IW + GW + LOG2B + 2;
   localparam int SW    = $clog2(LOG2B + 1);

   if (!is_pow2(LANES) || LANES < 2 || LANES > 512) begin : g_bad_lanes
      $error("LANES must be a power of two in 2..512");
   end
   if (DW < 2 || IW < 1 || GW < 1) begin : g_bad_width
      $error("DW, IW and GW must be positive");
   end

   logic          clr_w, ld_w, fold_w, busy_w;
   logic [SW-1:0] step_w;
   logic [BW-1:0] base_w, stride_w;
   logic [IW:0]   count_w;

   tree_sum_ctrl #(.LANES(LANES), .IW(IW), .GW(GW), .BW(BW), .SW(SW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .elem_count_i(elem_count_i), .grp_count_i(grp_count_i), .grp_idx_i(grp_idx_i),
      .clr_o(clr_w), .ld_o(ld_w), .fold_o(fold_w), .busy_o(busy_w), .done_o(done_o),
      .step_o(step_w), .base_o(base_w), .stride_o(stride_w), .count_o(count_w)
   );

   tree_sum_scratch #(.LANES(LANES), .DW(DW), .IW(IW), .BW(BW), .SW(SW)) u_scr (
      .clk(clk), .rst_n(rst_n), .clr_i(clr_w), .ld_i(ld_w), .fold_i(fold_w),
      .step_i(step_w), .base_i(base_w), .count_i(count_w),
      .rd_data_i(rd_data_i), .sum_o(sum_o)
   );

   for (genvar j = 0; j < 2*LANES; j++) begin : g_addr
      assign rd_addr_o[j*IW +: IW] = base_w[IW-1:0] + IW'(j);
   end
endmodule

// File: rtl/tree_sum_chk.sv
module tree_sum_chk #(
   parameter int LANES = 8,
   parameter int IW    = 10,
   parameter int GW    = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  done_o,
   input logic                  ld_w,
   input logic                  fold_w,
   input logic                  busy_w,
   input logic [GW-1:0]         grp_idx_i,
   input logic [2*LANES*IW-1:0] rd_addr_o,
   input logic [IW+GW+$clog2(LANES)+1:0] stride_w,
   input logic [IW:0]           count_w
);
   localparam int LOG2B = $clog2(LANES);
   localparam int SHIFT = LOG2B + 1;

   logic [9:0]    fold_run;
   logic [IW-1:0] addr0;
   assign addr0 = rd_addr_o[IW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n)      fold_run <= '0;
      else if (ld_w)   fold_run <= '0;
      else if (fold_w) fold_run <= fold_run + 1'b1;
   end

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R3
   first_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ld_w) |-> addr0 == (IW'($past(grp_idx_i)) << SHIFT));

   // R3
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_w && $past(ld_w)) |-> addr0 == $past(addr0) + stride_w[IW-1:0]);

   // R5
   load_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fold_w) |-> $past(ld_w));

   // R6
   fold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (fold_run == 10'(LOG2B)) && $past(fold_w));

   // R8
   hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_w && $past(busy_w)) |-> $stable(count_w));
endmodule

bind tree_sum_engine tree_sum_chk #(.LANES(LANES), .IW(IW), .GW(GW)) u_chk (
   .clk(clk), .rst_n(rst_n), .done_o(done_o), .ld_w(ld_w), .fold_w(fold_w),
   .busy_w(busy_w), .grp_idx_i(grp_idx_i), .rd_addr_o(rd_addr_o),
   .stride_w(stride_w), .count_w(count_w)
);

// File: tb/tree_sum_engine_test.sv
module tree_sum_engine_test;
   localparam int CLK_PERIOD = 10;
   localparam int B  = 8;
   localparam int DW = 32;
   localparam int IW = 10;
   localparam int GW = 4;
   localparam int LOG2B = $clog2(B);
   localparam int MEMSZ = 1 << IW;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                start_i = 1'b0;
   logic [IW:0]         elem_count_i = '0;
   logic [GW-1:0]       grp_count_i = '0;
   logic [GW-1:0]       grp_idx_i = '0;
   logic [2*B*IW-1:0]   rd_addr_o;
   logic [2*B*DW-1:0]   rd_data_i;
   logic                done_o;
   logic [DW-1:0]       sum_o;

   logic [DW-1:0] mem [MEMSZ];
   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   always_comb
      for (int j = 0; j < 2*B; j++)
         rd_data_i[j*DW +: DW] = mem[rd_addr_o[j*IW +: IW]];

   tree_sum_engine #(.LANES(B), .DW(DW), .IW(IW), .GW(GW)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .elem_count_i(elem_count_i),
      .grp_count_i(grp_count_i), .grp_idx_i(grp_idx_i), .rd_addr_o(rd_addr_o),
      .rd_data_i(rd_data_i), .done_o(done_o), .sum_o(sum_o)
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] ref_sum(int n, int g_cnt, int g);
      logic [DW-1:0] s = '0;
      int ge = (g_cnt == 0) ? 1 : g_cnt;
      for (int k = 0; k < n; k++)
         if (((k / (2*B)) % ge) == g) s += mem[k];
      return s;
   endfunction

   function automatic int ref_loads(int n, int g_cnt, int g);
      int ge = (g_cnt == 0) ? 1 : g_cnt;
      int st = 2*B*ge;
      int b  = g*2*B + st;
      int kk = 1;
      while (b < n) begin kk++; b += st; end
      return kk;
   endfunction

   task automatic run(input int n, input int g_cnt, input int g, input bit poke, input string tag);
      logic [DW-1:0] exp_s = ref_sum(n, g_cnt, g);
      int exp_k = ref_loads(n, g_cnt, g);
      int stv = 2*B*((g_cnt == 0) ? 1 : g_cnt);
      int cyc = 0;
      @(negedge clk);
      elem_count_i = (IW+1)'(n);
      grp_count_i  = GW'(g_cnt);
      grp_idx_i    = GW'(g);
      start_i      = 1'b1;
      @(posedge clk); #1;
      start_i = 1'b0;
      // R3 first window at group*2B
      check(rd_addr_o[IW-1:0] == IW'(g*2*B), {tag, " R3 first addr"}, rd_addr_o[IW-1:0], g*2*B);
      while (!done_o && cyc < 5000) begin
         @(posedge clk); #1;
         cyc++;
         if (cyc == 1 && exp_k > 1)
            check(rd_addr_o[IW-1:0] == IW'(g*2*B + stv), {tag, " R3 step addr"},
                  rd_addr_o[IW-1:0], IW'(g*2*B + stv));
         if (cyc == 1 && poke) begin
            start_i = 1'b1;           // R8 ignored while busy
            elem_count_i = (IW+1)'(n + 37);
            grp_idx_i = GW'(g + 1);
         end else start_i = 1'b0;
      end
      if (cyc >= 5000) check(1'b0, {tag, " watchdog done"}, cyc, exp_k + LOG2B);
      // R5 R6 latency
      check(cyc == exp_k + LOG2B, {tag, " R5 R6 latency"}, cyc, exp_k + LOG2B);
      // R2 R7 result with done
      check(sum_o == exp_s, {tag, " R2 R7 sum"}, $signed(sum_o), $signed(exp_s));
      @(posedge clk); #1;
      check(!done_o, {tag, " R7 single cycle"}, done_o, 0);
      start_i = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD*150000);
      check(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int dir [16] = '{10, 1, 8, -1, 0, -2, 3, 5, -2, -3, 2, 7, 0, 11, 0, 2};
      void'($urandom(32'd20240611));
      for (int k = 0; k < MEMSZ; k++) mem[k] = 32'h0BAD_0000 + k;
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      check(!done_o, "R1 done low", done_o, 0);
      check(sum_o == '0, "R1 sum zero", sum_o, 0);
      @(negedge clk); rst_n = 1'b1;

      // R11 directed vector, garbage beyond n (R4)
      for (int k = 0; k < 16; k++) mem[k] = DW'(dir[k]);
      run(16, 1, 0, 1'b0, "R11");
      check(sum_o == 32'd41, "R11 total 41", $signed(sum_o), 41);

      // R4 short count inside one window
      run(5, 1, 0, 1'b0, "R4 n5");
      run(0, 1, 0, 1'b0, "R4 n0");

      // R9 wrap on overflow
      for (int k = 0; k < 16; k++) mem[k] = 32'h7000_0000;
      run(16, 1, 0, 1'b0, "R9 wrap");
      check(sum_o == 32'h0, "R9 wrapped to zero", sum_o, 0);
      mem[0] = 32'h7FFF_FFFF; mem[1] = 32'h1;
      run(2, 1, 0, 1'b0, "R9 min");

      // R8 start and inputs changed mid-run
      for (int k = 0; k < MEMSZ; k++) mem[k] = $urandom;
      run(200, 2, 1, 1'b1, "R8 poke");
      // group count zero treated as one (R2)
      run(100, 0, 0, 1'b0, "R2 g0");
      // R10 back-to-back runs start from cleared slots
      run(64, 1, 0, 1'b0, "R10 first");
      run(3, 1, 0, 1'b0, "R10 second");

      for (int t = 0; t < 30; t++) begin
         int n  = $urandom_range(1, MEMSZ - 1);
         int gc = $urandom_range(1, 6);
         int gi = $urandom_range(0, gc - 1);
         for (int k = 0; k < MEMSZ; k++) mem[k] = $urandom;
         run(n, gc, gi, 1'b0, "R2 random");
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule